// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Tracker

This block keeps the interrupt state of one processor core across 256 vectors. It holds three bitmaps: pending requests, vectors in service, and the trigger kind of each vector (level or edge). Requests come in with a vector number, a delivery mode and a trigger flag. The block accepts them only while both enables are set. It always offers the core the highest pending vector, as long as that vector's priority class beats the current processor priority.

The processor priority comes from a software-written task priority and from the class of the highest vector in service. The class of a vector is its upper four bits. When the core pulses acknowledge, the offered vector moves from pending to in service. An end-of-interrupt strobe retires the highest vector in service. If that vector was level-triggered, a one-cycle broadcast carries its number to an external interrupt controller, which can then re-sample the level source.

Top module: `vec_irq_tracker`

## Requirements
- R1: `offer_vec` is the highest-numbered pending vector. `offer_valid` is low whenever no vector is pending or R3 blocks the offer.
- R2: `ppr_out` equals the task priority when the task priority's upper nibble is at least the upper nibble of the highest in-service vector. Otherwise it equals that vector with its low nibble cleared. An empty in-service set counts as vector 0.
- R3: a pending vector is offered only if its value with the low nibble cleared is strictly greater than `ppr_out`.
- R4: at a clock edge with `ack` high and `offer_valid` high, the offered vector's in-service bit is set and its pending bit is cleared. `ppr_out` reflects the new in-service set in the following cycle. An `ack` while `offer_valid` is low has no effect.
- R5: at an edge with `eoi_we` high, the highest in-service bit is cleared. If that vector's trigger bit was set, the trigger bit is cleared and `eoi_bcast_valid` is high for exactly the next cycle, with `eoi_bcast_vec` holding the vector. An `eoi_we` with an empty in-service set changes nothing.
- R6: an accepted request sets the vector's pending bit and records the trigger kind (1 = level, 0 = edge). A level request whose vector is already pending is discarded and leaves the trigger bit unchanged. An edge request on a pending vector sets the trigger bit to edge.
- R7: requests are dropped unless `hw_en` and `sw_en` are both high.
- R8: only `req_mode` 0 (fixed) and 1 (lowest priority) are accepted. Every other mode value is dropped.
- R9: a `tpr_we` pulse stores `tpr_wdata` as the task priority. The value is readable on `tpr_rdata`, and `ppr_out` uses it from the next cycle.
- R10: reset clears all three bitmaps, the task priority and the broadcast output.
- R11: when a request and an acknowledge name the same vector in one cycle, the acknowledge is applied first. The vector then goes into service and is pending again, with the request's trigger kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_en | input | 1 | Global hardware enable |
| sw_en | input | 1 | Software enable |
| req_valid | input | 1 | Request strobe |
| req_vec | input | 8 | Requested vector |
| req_mode | input | 3 | Delivery mode (0 fixed, 1 lowest priority) |
| req_level | input | 1 | Trigger kind, 1 = level |
| ack | input | 1 | Core accepts the offered vector |
| eoi_we | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority write value |
| tpr_rdata | output | 8 | Current task priority |
| ppr_out | output | 8 | Current processor priority |
| offer_valid | output | 1 | A vector is deliverable |
| offer_vec | output | 8 | Vector offered to the core |
| eoi_bcast_valid | output | 1 | Level-vector EOI notification pulse |
| eoi_bcast_vec | output | 8 | Vector retired by that EOI |

## Verification
A scripted sequence nests requests of rising and falling class, so the offer is seen both granted and withheld by the processor priority. The task priority is raised above and lowered below the in-service class, which tells the two R2 cases apart. EOI runs cover level vectors, edge vectors and an empty in-service set, so a missing, spurious or misnumbered broadcast shows up. Directed cases cover the enables, illegal modes, repeated level and edge requests, a request and acknowledge in the same cycle, and vector 255.

// File: rtl/irq_pkg.sv
// Shared constants for the vectored interrupt tracker.
// Assumes vectors are at least 8 bits wide so a class nibble exists.
package irq_pkg;
    localparam int unsigned CLASS_BITS = 4;
    localparam int unsigned MODE_W     = 3;
    localparam logic [MODE_W-1:0] MODE_FIXED  = 3'd0;
    localparam logic [MODE_W-1:0] MODE_LOWEST = 3'd1;
endpackage

// File: rtl/irq_prio_find.sv
// Highest-set-bit search over a bitmap, fully combinational.
// Assumes W is a power of two. any_o is low for an empty bitmap, and idx_o is 0 then.
module irq_prio_find #(
    parameter int unsigned W  = 256,
    localparam int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  bits_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    // scan upward so the last set bit seen is the highest
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (bits_i[i]) begin
                idx_o = IW'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_ppr_calc.sv
// Processor priority from the task priority and the highest in-service vector.
// Assumes the class is the top CLASS_BITS of a vector.
module irq_ppr_calc
    import irq_pkg::*;
#(
    parameter int unsigned VW = 8,
    localparam int unsigned LOW_W = VW - CLASS_BITS
) (
    input  logic [VW-1:0] tpr_i,
    input  logic [VW-1:0] isr_top_i,
    input  logic          isr_any_i,
    output logic [VW-1:0] ppr_o
);
    logic [VW-1:0] isr_v;

    // choose the task priority unless the in-service class is higher
    always_comb begin
        isr_v = isr_any_i ? isr_top_i : '0;
        if (tpr_i[VW-1 -: CLASS_BITS] >= isr_v[VW-1 -: CLASS_BITS])
            ppr_o = tpr_i;
        else
            ppr_o = {isr_v[VW-1 -: CLASS_BITS], {LOW_W{1'b0}}};
    end
endmodule

// File: rtl/vec_irq_tracker.sv
// Vectored interrupt tracker: pending, in-service and trigger bitmaps,
// priority gating of the offered vector, acknowledge and end-of-interrupt.
// Assumes one request, one ack and one EOI at most per cycle; ack is applied
// before a request in the same cycle.
module vec_irq_tracker
    import irq_pkg::*;
#(
    parameter int unsigned NVEC = 256,
    localparam int unsigned VW   = $clog2(NVEC),
    localparam int unsigned LOW_W = VW - CLASS_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic              sw_en,
    input  logic              req_valid,
    input  logic [VW-1:0]     req_vec,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              req_level,
    input  logic              ack,
    input  logic              eoi_we,
    input  logic              tpr_we,
    input  logic [VW-1:0]     tpr_wdata,
    output logic [VW-1:0]     tpr_rdata,
    output logic [VW-1:0]     ppr_out,
    output logic              offer_valid,
    output logic [VW-1:0]     offer_vec,
    output logic              eoi_bcast_valid,
    output logic [VW-1:0]     eoi_bcast_vec
);
    localparam logic [NVEC-1:0] ONE = {{(NVEC-1){1'b0}}, 1'b1};

    logic [NVEC-1:0] irr_q, isr_q, tmr_q;
    logic [NVEC-1:0] irr_d, isr_d, tmr_d;
    logic [VW-1:0]   tpr_q;
    logic [VW-1:0]   irr_top, isr_top;
    logic            irr_any, isr_any;
    logic            ack_fire, eoi_fire, req_ok, req_drop;
    logic [NVEC-1:0] ack_bit, eoi_bit, irr_after_ack;

    irq_prio_find #(.W(NVEC)) u_irr_find (
        .bits_i(irr_q), .idx_o(irr_top), .any_o(irr_any)
    );

    irq_prio_find #(.W(NVEC)) u_isr_find (
        .bits_i(isr_q), .idx_o(isr_top), .any_o(isr_any)
    );

    irq_ppr_calc #(.VW(VW)) u_ppr (
        .tpr_i(tpr_q), .isr_top_i(isr_top), .isr_any_i(isr_any), .ppr_o(ppr_out)
    );

    // offer the top pending vector when its class clears the processor priority
    always_comb begin
        offer_vec   = irr_top;
        offer_valid = irr_any && ({irr_top[VW-1 -: CLASS_BITS], {LOW_W{1'b0}}} > ppr_out);
    end

    // next-state of the three bitmaps: ack, then EOI, then the new request
    always_comb begin
        ack_fire      = ack && offer_valid;
        eoi_fire      = eoi_we && isr_any;
        ack_bit       = ack_fire ? (ONE << offer_vec) : '0;
        eoi_bit       = eoi_fire ? (ONE << isr_top) : '0;
        req_ok        = req_valid && hw_en && sw_en &&
                        (req_mode == MODE_FIXED || req_mode == MODE_LOWEST);
        irr_after_ack = irr_q & ~ack_bit;
        req_drop      = req_level && irr_after_ack[req_vec];
        irr_d         = irr_after_ack;
        isr_d         = (isr_q & ~eoi_bit) | ack_bit;
        tmr_d         = tmr_q & ~eoi_bit;
        if (req_ok && !req_drop) begin
            irr_d[req_vec] = 1'b1;
            tmr_d[req_vec] = req_level;
        end
    end

    // state registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
            tpr_q <= '0;
        end else begin
            irr_q <= irr_d;
            isr_q <= isr_d;
            tmr_q <= tmr_d;
            if (tpr_we) tpr_q <= tpr_wdata;
        end
    end

    // one-cycle notification for a retired level-triggered vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_bcast_valid <= 1'b0;
            eoi_bcast_vec   <= '0;
        end else begin
            eoi_bcast_valid <= eoi_fire && tmr_q[isr_top];
            eoi_bcast_vec   <= isr_top;
        end
    end

    assign tpr_rdata = tpr_q;

    // R3: offered class is strictly above the processor priority
    p_offer_above_ppr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> ({offer_vec[VW-1 -: CLASS_BITS], {LOW_W{1'b0}}} > ppr_out));

    // R2: processor priority never falls below the task priority
    p_ppr_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ppr_out >= tpr_rdata);

    // R4: after an acknowledge the priority covers the acked class
    p_ack_raises_ppr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && offer_valid && !eoi_we && !tpr_we) |=>
        (ppr_out >= {$past(offer_vec[VW-1 -: CLASS_BITS]), {LOW_W{1'b0}}}));

    // R5: a broadcast only follows an EOI strobe
    p_bcast_after_eoi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast_valid |-> $past(eoi_we));

    // R7: with an enable low and no ack, pending bits do not change
    p_disabled_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(hw_en && sw_en) && !ack) |=> (irr_q == $past(irr_q)));

    // R8: an unsupported mode with no ack leaves pending bits alone
    p_bad_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode > MODE_LOWEST && !ack) |=> (irr_q == $past(irr_q)));

    // R9: task priority write lands in one cycle
    p_tpr_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tpr_we |=> (tpr_rdata == $past(tpr_wdata)));
endmodule

// File: tb/vec_irq_tracker_tb_top.sv
`timescale 1ns/1ps
module vec_irq_tracker_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_en = 1'b1, sw_en = 1'b1;
    logic       req_valid = 1'b0, req_level = 1'b0;
    logic [7:0] req_vec = '0;
    logic [2:0] req_mode = '0;
    logic       ack = 1'b0, eoi_we = 1'b0, tpr_we = 1'b0;
    logic [7:0] tpr_wdata = '0;
    logic [7:0] tpr_rdata, ppr_out, offer_vec, eoi_bcast_vec;
    logic       offer_valid, eoi_bcast_valid;
    int total = 0, bad = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    vec_irq_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
        .req_valid(req_valid), .req_vec(req_vec), .req_mode(req_mode),
        .req_level(req_level), .ack(ack), .eoi_we(eoi_we),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .tpr_rdata(tpr_rdata),
        .ppr_out(ppr_out), .offer_valid(offer_valid), .offer_vec(offer_vec),
        .eoi_bcast_valid(eoi_bcast_valid), .eoi_bcast_vec(eoi_bcast_vec)
    );

    // op codes: 0 idle, 1 request, 2 ack, 3 eoi, 4 tpr write, 5 request with mode 2
    // row: op[47:44] a[43:36] lvl[35] ov[34] ovec[33:26] ppr[25:18] bv[17] bvec[16:9]
    localparam int NROW = 16;
    localparam logic [47:0] ROWS [NROW] = '{
        {4'd1, 8'h30, 1'b0, 1'b1, 8'h30, 8'h00, 1'b0, 8'h00, 9'd0},
        {4'd1, 8'h51, 1'b1, 1'b1, 8'h51, 8'h00, 1'b0, 8'h00, 9'd0},
        {4'd1, 8'h45, 1'b0, 1'b1, 8'h51, 8'h00, 1'b0, 8'h00, 9'd0},
        {4'd2, 8'h00, 1'b0, 1'b0, 8'h00, 8'h50, 1'b0, 8'h00, 9'd0},
        {4'd4, 8'h62, 1'b0, 1'b0, 8'h00, 8'h62, 1'b0, 8'h00, 9'd0},
        {4'd4, 8'h20, 1'b0, 1'b0, 8'h00, 8'h50, 1'b0, 8'h00, 9'd0},
        {4'd3, 8'h00, 1'b0, 1'b1, 8'h45, 8'h20, 1'b1, 8'h51, 9'd0},
        {4'd2, 8'h00, 1'b0, 1'b0, 8'h00, 8'h40, 1'b0, 8'h00, 9'd0},
        {4'd1, 8'h90, 1'b1, 1'b1, 8'h90, 8'h40, 1'b0, 8'h00, 9'd0},
        {4'd2, 8'h00, 1'b0, 1'b0, 8'h00, 8'h90, 1'b0, 8'h00, 9'd0},
        {4'd3, 8'h00, 1'b0, 1'b0, 8'h00, 8'h40, 1'b1, 8'h90, 9'd0},
        {4'd3, 8'h00, 1'b0, 1'b1, 8'h30, 8'h20, 1'b0, 8'h00, 9'd0},
        {4'd5, 8'hA0, 1'b1, 1'b1, 8'h30, 8'h20, 1'b0, 8'h00, 9'd0},
        {4'd3, 8'h00, 1'b0, 1'b1, 8'h30, 8'h20, 1'b0, 8'h00, 9'd0},
        {4'd2, 8'h00, 1'b0, 1'b0, 8'h00, 8'h30, 1'b0, 8'h00, 9'd0},
        {4'd3, 8'h00, 1'b0, 1'b0, 8'h00, 8'h20, 1'b0, 8'h00, 9'd0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one operation across one rising edge, then release the inputs
    task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic lvl);
        @(negedge clk);
        req_valid = (op == 4'd1 || op == 4'd5);
        req_mode  = (op == 4'd5) ? 3'd2 : 3'd0;
        req_vec   = a;
        req_level = lvl;
        ack       = (op == 4'd2);
        eoi_we    = (op == 4'd3);
        tpr_we    = (op == 4'd4);
        tpr_wdata = a;
        @(posedge clk);
        #1;
        req_valid = 1'b0; ack = 1'b0; eoi_we = 1'b0; tpr_we = 1'b0; req_mode = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 offer_valid after reset", int'(offer_valid), 0);
        chk("R10 ppr after reset", int'(ppr_out), 0);
        chk("R10 tpr after reset", int'(tpr_rdata), 0);
        chk("R10 bcast after reset", int'(eoi_bcast_valid), 0);

        // table walk: R1 R2 R3 R4 R5 R8 R9
        for (int i = 0; i < NROW; i++) begin
            logic [47:0] r;
            r = ROWS[i];
            apply(r[47:44], r[43:36], r[35]);
            chk($sformatf("R3 row %0d offer_valid", i), int'(offer_valid), int'(r[34]));
            if (r[34]) chk($sformatf("R1 row %0d offer_vec", i), int'(offer_vec), int'(r[33:26]));
            chk($sformatf("R2 row %0d ppr", i), int'(ppr_out), int'(r[25:18]));
            chk($sformatf("R5 row %0d bcast_valid", i), int'(eoi_bcast_valid), int'(r[17]));
            if (r[17]) chk($sformatf("R5 row %0d bcast_vec", i), int'(eoi_bcast_vec), int'(r[16:9]));
        end
        @(negedge clk);
        chk("R5 bcast lasts one cycle", int'(eoi_bcast_valid), 0);

        // R9: task priority readback
        apply(4'd4, 8'h35, 1'b0);
        chk("R9 tpr readback", int'(tpr_rdata), 'h35);
        chk("R9 ppr follows tpr", int'(ppr_out), 'h35);
        apply(4'd4, 8'h00, 1'b0);

        // R7: enables gate requests
        hw_en = 1'b0;
        apply(4'd1, 8'h70, 1'b0);
        chk("R7 hw_en low drops request", int'(offer_valid), 0);
        hw_en = 1'b1; sw_en = 1'b0;
        apply(4'd1, 8'h70, 1'b0);
        chk("R7 sw_en low drops request", int'(offer_valid), 0);
        sw_en = 1'b1;

        // R4: ack with nothing offered does nothing
        apply(4'd2, 8'h00, 1'b0);
        chk("R4 idle ack keeps ppr", int'(ppr_out), 0);

        // R6: level re-request on pending edge vector is discarded
        apply(4'd1, 8'h80, 1'b0);
        apply(4'd1, 8'h80, 1'b1);
        apply(4'd2, 8'h00, 1'b0);
        apply(4'd3, 8'h00, 1'b0);
        chk("R6 discarded level keeps edge", int'(eoi_bcast_valid), 0);
        // R6: edge re-request turns a level vector into edge
        apply(4'd1, 8'h81, 1'b1);
        apply(4'd1, 8'h81, 1'b0);
        apply(4'd2, 8'h00, 1'b0);
        apply(4'd3, 8'h00, 1'b0);
        chk("R6 edge re-request clears level", int'(eoi_bcast_valid), 0);

        // R11: same-cycle ack and request of one vector
        apply(4'd1, 8'hC0, 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_vec = 8'hC0; req_level = 1'b1; ack = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0; ack = 1'b0;
        @(negedge clk);
        chk("R11 acked vector in service", int'(ppr_out), 'hC0);
        chk("R11 vector pending again but blocked", int'(offer_valid), 0);
        apply(4'd3, 8'h00, 1'b0);
        chk("R11 new level kind broadcast", int'(eoi_bcast_valid), 1);
        chk("R11 broadcast vector", int'(eoi_bcast_vec), 'hC0);
        chk("R11 re-offered", int'(offer_vec), 'hC0);
        apply(4'd2, 8'h00, 1'b0);
        apply(4'd3, 8'h00, 1'b0);
        chk("R5 trigger bit cleared by EOI", int'(eoi_bcast_valid), 0);

        // R1: top vector 255
        apply(4'd1, 8'hFF, 1'b1);
        chk("R1 vector 255 offered", int'(offer_vec), 'hFF);
        apply(4'd2, 8'h00, 1'b0);
        chk("R2 ppr for vector 255", int'(ppr_out), 'hF0);
        apply(4'd3, 8'h00, 1'b0);
        chk("R5 vector 255 broadcast", int'(eoi_bcast_vec), 'hFF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule